// File: doc/BRIEF.md
# Scratchpad-to-Peripheral Memory Ring Relay

The relay moves a block of 128-bit words from an on-chip scratchpad to one of two peripheral streams, staging every word in a ring buffer placed in main memory. Two engines work at once: a fill engine reads scratchpad words and writes them into the ring, and a drain engine reads ring slots back from memory and presents them on the selected output channel. Main memory acts as an elastic store, so a stalled peripheral holds back only the drain engine. The fill engine keeps emptying the scratchpad until the ring has no free slot.

Software sets up a job through configuration pins: a ring base address, the ring size as a power of two, the scratchpad start address, a word count and the drain channel. A one-cycle start pulse launches the job. Addresses on every port count 16-byte words. Ring slot addresses are formed as the ring base OR-ed with the masked slot index. Each of the three ring pointers (reserve, commit, read) carries one extra wrap bit, and that bit tells a full ring from an empty one. The busy flag drops and the done flag rises in the cycle after the last word leaves on the output stream.

Top module: `ring_relay`

## Requirements
- R1: After reset, spr_req_o, mem_wr_req_o, mem_rd_req_o, every bit of out_valid_o, busy_o and done_o are all low.
- R2: A start pulse while busy_o is low latches the configuration, clears done_o and raises busy_o on the next cycle (unless the count is zero). A start pulse while busy_o is high has no effect on the running job or on its configuration.
- R3: The k-th scratchpad read uses address cfg_spr_base_i+k, and its data arrives on spr_rdata_i one cycle later. The k-th memory write carries that data to word address ring_base | (k mod 2^log2).
- R4: The k-th memory read uses word address ring_base | (k mod 2^log2). Read data are delivered in order on out_valid_o[sel]/out_data_o, where sel 0 is bit 0 and sel 1 is bit 1. The other valid bit stays low.
- R5: The count of words written minus the count of reads granted never exceeds the ring size. While the selected peripheral holds ready low and memory grants every request, exactly ring_size+4 words get written (4 is the drain buffer depth), and then the fill engine stops.
- R6: A ring slot is never read before the write that fills it has been granted.
- R7: In the cycle after the last word is accepted on the output, done_o rises and busy_o falls in the same cycle. done_o then holds until the next accepted start.
- R8: A start with a word count of zero raises done_o on the next cycle, leaves busy_o low and issues no memory or scratchpad request.
- R9: A memory write or read request, with its address and write data, is held stable until it is granted. out_valid_o and out_data_o are held stable while the selected ready is low.
- R10: A ring of a single slot (log2 of 0) relays words correctly in order.
- R11: A ring size log2 greater than PTR_W is treated as PTR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a job |
| cfg_count_i | input | CNT_W | Number of words to relay |
| cfg_spr_base_i | input | ADDR_W | First scratchpad word address |
| cfg_ring_base_i | input | ADDR_W | Ring base word address, low log2 bits zero |
| cfg_ring_log2_i | input | LOG_W | Ring size as log2 of slots |
| cfg_sel_i | input | SEL_W | Drain channel select |
| busy_o | output | 1 | Job running |
| done_o | output | 1 | Last job complete |
| spr_req_o | output | 1 | Scratchpad read request |
| spr_addr_o | output | ADDR_W | Scratchpad read word address |
| spr_rdata_i | input | DATA_W | Scratchpad read data, one cycle after request |
| mem_wr_req_o | output | 1 | Memory write request |
| mem_wr_addr_o | output | ADDR_W | Memory write word address |
| mem_wr_data_o | output | DATA_W | Memory write data |
| mem_wr_gnt_i | input | 1 | Memory write grant |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | ADDR_W | Memory read word address |
| mem_rd_gnt_i | input | 1 | Memory read grant |
| mem_rd_valid_i | input | 1 | Memory read data valid, in grant order |
| mem_rd_data_i | input | DATA_W | Memory read data |
| out_valid_o | output | NUM_CH | Per-channel output valid |
| out_data_o | output | DATA_W | Output data shared by channels |
| out_ready_i | input | NUM_CH | Per-channel ready |

## Verification
The assertions take for granted that memory returns exactly one read response for each granted read, in grant order, and never raises mem_rd_valid_i otherwise. They also take for granted that the ring base has its low log2 bits clear, and that the ring memory is written only by the relay. The bench's memory model keeps to this. Its return path is a fixed-latency pipeline fed only by granted reads. It picks ring bases aligned to the largest ring used, and it gives every job scratchpad contents from an address-derived pattern, so the expected output follows from the address alone. Grant and ready randomness comes from a bench LFSR. Random grants only delay traffic and never invent responses.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_DATA_W   = 128;
  localparam int unsigned RR_ADDR_W   = 32;
  localparam int unsigned RR_PTR_W    = 10;
  localparam int unsigned RR_CNT_W    = 16;
  localparam int unsigned RR_NUM_CH   = 2;
  localparam int unsigned RR_FILL_BUF = 2;
  localparam int unsigned RR_DRN_BUF  = 4;
  // ring pointer roles
  localparam int unsigned RR_P_RES    = 0;
  localparam int unsigned RR_P_CMT    = 1;
  localparam int unsigned RR_P_RD     = 2;
  localparam int unsigned RR_NUM_PTR  = 3;
endpackage

// File: rtl/rr_ring_ptr.sv
module rr_ring_ptr #(
  parameter int unsigned PTR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] mask_i,
  output logic [PTR_W-1:0] idx_o,
  output logic             wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      wrap_o <= 1'b0;
    end else if (clr_i) begin
      idx_o  <= '0;
      wrap_o <= 1'b0;
    end else if (adv_i) begin
      if (idx_o == mask_i) begin
        idx_o  <= '0;
        wrap_o <= ~wrap_o;
      end else begin
        idx_o  <= idx_o + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rr_fill.sv
module rr_fill #(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTR_W     = 10,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BUF_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] spr_base_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [PTR_W-1:0]  commit_idx_i,
  input  logic              ring_full_i,
  output logic              reserve_o,
  output logic              commit_o,
  output logic              spr_req_o,
  output logic [ADDR_W-1:0] spr_addr_o,
  input  logic [DATA_W-1:0] spr_rdata_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_gnt_i
);
  localparam int unsigned BCW = $clog2(BUF_DEPTH + 1);

  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] saddr_q;
  logic              pend_q;
  logic [BCW-1:0]    b_cnt;
  logic              b_empty;
  logic              issue, pop;

  // one slot per word in flight: buffered plus pending scratchpad read
  assign issue = run_i && (left_q != '0) && !ring_full_i &&
                 ((32'(b_cnt) + 32'(pend_q)) < 32'(BUF_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      saddr_q <= '0;
      pend_q  <= 1'b0;
    end else if (load_i) begin
      left_q  <= count_i;
      saddr_q <= spr_base_i;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        left_q  <= left_q - CNT_W'(1);
        saddr_q <= saddr_q + ADDR_W'(1);
      end
    end
  end

  rr_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_i),
    .push_i  (pend_q),
    .wdata_i (spr_rdata_i),
    .pop_i   (pop),
    .rdata_o (mem_wr_data_o),
    .count_o (b_cnt),
    .empty_o (b_empty)
  );

  assign spr_req_o     = issue;
  assign spr_addr_o    = saddr_q;
  assign mem_wr_req_o  = !b_empty;
  assign pop           = mem_wr_req_o && mem_wr_gnt_i;
  assign mem_wr_addr_o = ring_base_i | ADDR_W'(commit_idx_i);
  assign reserve_o     = issue;
  assign commit_o      = pop;
endmodule

// File: rtl/rr_drain.sv
module rr_drain #(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTR_W     = 10,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned BUF_DEPTH = 4,
  localparam int unsigned SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  input  logic              ring_empty_i,
  output logic              rd_adv_o,
  output logic              last_o,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_gnt_i,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic [NUM_CH-1:0] out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic [NUM_CH-1:0] out_ready_i
);
  localparam int unsigned BCW = $clog2(BUF_DEPTH + 1);

  logic [CNT_W-1:0] left_q;
  logic [BCW-1:0]   pend_q;
  logic [BCW-1:0]   b_cnt;
  logic             b_empty;
  logic             issue, gnt, pop, rdy_sel;

  // credit: reads in flight plus buffered words never exceed buffer depth
  assign issue = run_i && !ring_empty_i &&
                 ((32'(pend_q) + 32'(b_cnt)) < 32'(BUF_DEPTH));
  assign gnt   = issue && mem_rd_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      pend_q <= '0;
    end else if (load_i) begin
      left_q <= count_i;
      pend_q <= '0;
    end else begin
      pend_q <= pend_q + BCW'(gnt) - BCW'(mem_rd_valid_i);
      if (pop) left_q <= left_q - CNT_W'(1);
    end
  end

  rr_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_i),
    .push_i  (mem_rd_valid_i),
    .wdata_i (mem_rd_data_i),
    .pop_i   (pop),
    .rdata_o (out_data_o),
    .count_o (b_cnt),
    .empty_o (b_empty)
  );

  assign rdy_sel = out_ready_i[sel_i];
  assign pop     = !b_empty && rdy_sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign out_valid_o[c] = !b_empty && (sel_i == SEL_W'(c));
  end

  assign mem_rd_req_o  = issue;
  assign mem_rd_addr_o = ring_base_i | ADDR_W'(rd_idx_i);
  assign rd_adv_o      = gnt;
  assign last_o        = pop && (left_q == CNT_W'(1));
endmodule

// File: rtl/ring_relay.sv
module ring_relay import rr_pkg::*; #(
  parameter int unsigned DATA_W    = RR_DATA_W,
  parameter int unsigned ADDR_W    = RR_ADDR_W,
  parameter int unsigned PTR_W     = RR_PTR_W,
  parameter int unsigned CNT_W     = RR_CNT_W,
  parameter int unsigned NUM_CH    = RR_NUM_CH,
  parameter int unsigned FILL_BUF  = RR_FILL_BUF,
  parameter int unsigned DRAIN_BUF = RR_DRN_BUF,
  localparam int unsigned LOG_W    = $clog2(PTR_W + 1),
  localparam int unsigned SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [ADDR_W-1:0] cfg_spr_base_i,
  input  logic [ADDR_W-1:0] cfg_ring_base_i,
  input  logic [LOG_W-1:0]  cfg_ring_log2_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              spr_req_o,
  output logic [ADDR_W-1:0] spr_addr_o,
  input  logic [DATA_W-1:0] spr_rdata_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_gnt_i,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_gnt_i,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic [NUM_CH-1:0] out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic [NUM_CH-1:0] out_ready_i
);
  logic [ADDR_W-1:0] base_q;
  logic [LOG_W-1:0]  log2_q;
  logic [SEL_W-1:0]  sel_q;
  logic              busy_q, done_q;
  logic              start_acc, last;
  logic [LOG_W-1:0]  log2_eff;
  logic [PTR_W:0]    ring_size;
  logic [PTR_W-1:0]  ring_mask;
  logic              ring_full, ring_empty;

  logic [RR_NUM_PTR-1:0] p_adv;
  logic [PTR_W-1:0]      p_idx  [RR_NUM_PTR];
  logic                  p_wrap [RR_NUM_PTR];

  assign start_acc = start_i && !busy_q;
  assign log2_eff  = (32'(cfg_ring_log2_i) > PTR_W) ? LOG_W'(PTR_W) : cfg_ring_log2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      log2_q <= '0;
      sel_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_acc) begin
      base_q <= cfg_ring_base_i;
      log2_q <= log2_eff;
      sel_q  <= cfg_sel_i;
      busy_q <= (cfg_count_i != '0);
      done_q <= (cfg_count_i == '0);
    end else if (last) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  // at log2 == PTR_W the truncated size is zero and the mask wraps to all ones
  assign ring_size = (PTR_W + 1)'(1) << log2_q;
  assign ring_mask = ring_size[PTR_W-1:0] - PTR_W'(1);

  for (genvar p = 0; p < RR_NUM_PTR; p++) begin : g_ptr
    rr_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_acc),
      .adv_i  (p_adv[p]),
      .mask_i (ring_mask),
      .idx_o  (p_idx[p]),
      .wrap_o (p_wrap[p])
    );
  end

  // reserve pointer guards space, commit pointer guards data
  assign ring_full  = (p_idx[RR_P_RES] == p_idx[RR_P_RD]) &&
                      (p_wrap[RR_P_RES] != p_wrap[RR_P_RD]);
  assign ring_empty = (p_idx[RR_P_CMT] == p_idx[RR_P_RD]) &&
                      (p_wrap[RR_P_CMT] == p_wrap[RR_P_RD]);

  rr_fill #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
    .CNT_W(CNT_W), .BUF_DEPTH(FILL_BUF)
  ) u_fill (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (start_acc),
    .run_i         (busy_q),
    .count_i       (cfg_count_i),
    .spr_base_i    (cfg_spr_base_i),
    .ring_base_i   (base_q),
    .commit_idx_i  (p_idx[RR_P_CMT]),
    .ring_full_i   (ring_full),
    .reserve_o     (p_adv[RR_P_RES]),
    .commit_o      (p_adv[RR_P_CMT]),
    .spr_req_o     (spr_req_o),
    .spr_addr_o    (spr_addr_o),
    .spr_rdata_i   (spr_rdata_i),
    .mem_wr_req_o  (mem_wr_req_o),
    .mem_wr_addr_o (mem_wr_addr_o),
    .mem_wr_data_o (mem_wr_data_o),
    .mem_wr_gnt_i  (mem_wr_gnt_i)
  );

  rr_drain #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .BUF_DEPTH(DRAIN_BUF)
  ) u_drain (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (start_acc),
    .run_i          (busy_q),
    .count_i        (cfg_count_i),
    .sel_i          (sel_q),
    .ring_base_i    (base_q),
    .rd_idx_i       (p_idx[RR_P_RD]),
    .ring_empty_i   (ring_empty),
    .rd_adv_o       (p_adv[RR_P_RD]),
    .last_o         (last),
    .mem_rd_req_o   (mem_rd_req_o),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_gnt_i   (mem_rd_gnt_i),
    .mem_rd_valid_i (mem_rd_valid_i),
    .mem_rd_data_i  (mem_rd_data_i),
    .out_valid_o    (out_valid_o),
    .out_data_o     (out_data_o),
    .out_ready_i    (out_ready_i)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 10,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              spr_req_o,
  input logic              mem_wr_req_o,
  input logic [ADDR_W-1:0] mem_wr_addr_o,
  input logic [DATA_W-1:0] mem_wr_data_o,
  input logic              mem_wr_gnt_i,
  input logic              mem_rd_req_o,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              mem_rd_gnt_i,
  input logic [NUM_CH-1:0] out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [NUM_CH-1:0] out_ready_i,
  input logic              ring_full,
  input logic              ring_empty,
  input logic [PTR_W-1:0]  ring_mask,
  input logic [ADDR_W-1:0] base_q,
  input logic [SEL_W-1:0]  sel_q
);
  logic [ADDR_W-1:0] hi_mask;
  assign hi_mask = ~(ADDR_W'(ring_mask));

  a_r5_no_fill_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_req_o |-> !ring_full);

  a_r6_no_read_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> !ring_empty);

  a_r4_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o != '0) |-> ($onehot0(out_valid_o) && out_valid_o[sel_q]));

  a_r3_wr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o |-> ((mem_wr_addr_o & hi_mask) == (base_q & hi_mask)));

  a_r4_rd_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> ((mem_rd_addr_o & hi_mask) == (base_q & hi_mask)));

  a_r9_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_req_o && !mem_wr_gnt_i) |=>
      (mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_gnt_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o)));

  a_r9_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o & ~out_ready_i) != '0) |=>
      ($stable(out_valid_o) && $stable(out_data_o)));

  a_r7_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(sel_q) && $stable(base_q)));
endmodule

bind ring_relay rr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .spr_req_o     (spr_req_o),
  .mem_wr_req_o  (mem_wr_req_o),
  .mem_wr_addr_o (mem_wr_addr_o),
  .mem_wr_data_o (mem_wr_data_o),
  .mem_wr_gnt_i  (mem_wr_gnt_i),
  .mem_rd_req_o  (mem_rd_req_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .mem_rd_gnt_i  (mem_rd_gnt_i),
  .out_valid_o   (out_valid_o),
  .out_data_o    (out_data_o),
  .out_ready_i   (out_ready_i),
  .ring_full     (ring_full),
  .ring_empty    (ring_empty),
  .ring_mask     (ring_mask),
  .base_q        (base_q),
  .sel_q         (sel_q)
);

// File: tb/tb_ring_relay.sv
module tb_ring_relay;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DRAIN_DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] cfg_count_i = '0;
  logic [AW-1:0] cfg_spr_base_i = '0;
  logic [AW-1:0] cfg_ring_base_i = '0;
  logic [3:0]    cfg_ring_log2_i = '0;
  logic [0:0]    cfg_sel_i = '0;
  logic          busy_o, done_o;
  logic          spr_req_o;
  logic [AW-1:0] spr_addr_o;
  logic [DW-1:0] spr_rdata_i = '0;
  logic          mem_wr_req_o;
  logic [AW-1:0] mem_wr_addr_o;
  logic [DW-1:0] mem_wr_data_o;
  logic          mem_wr_gnt_i = 1'b0;
  logic          mem_rd_req_o;
  logic [AW-1:0] mem_rd_addr_o;
  logic          mem_rd_gnt_i = 1'b0;
  logic          mem_rd_valid_i = 1'b0;
  logic [DW-1:0] mem_rd_data_i = '0;
  logic [1:0]    out_valid_o;
  logic [DW-1:0] out_data_o;
  logic [1:0]    out_ready_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_relay dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .cfg_count_i(cfg_count_i), .cfg_spr_base_i(cfg_spr_base_i),
    .cfg_ring_base_i(cfg_ring_base_i), .cfg_ring_log2_i(cfg_ring_log2_i),
    .cfg_sel_i(cfg_sel_i), .busy_o(busy_o), .done_o(done_o),
    .spr_req_o(spr_req_o), .spr_addr_o(spr_addr_o), .spr_rdata_i(spr_rdata_i),
    .mem_wr_req_o(mem_wr_req_o), .mem_wr_addr_o(mem_wr_addr_o),
    .mem_wr_data_o(mem_wr_data_o), .mem_wr_gnt_i(mem_wr_gnt_i),
    .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_gnt_i(mem_rd_gnt_i), .mem_rd_valid_i(mem_rd_valid_i),
    .mem_rd_data_i(mem_rd_data_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  int n_chk = 0;
  int n_err = 0;
  int wr_k = 0, rd_k = 0, out_k = 0;
  logic [AW-1:0] t_base = '0, t_spr = '0, t_mask = '0;
  int  t_size = 1;
  logic [0:0] t_sel = '0;
  int  gnt_mode = 0;   // 0 always grant, 1 random
  int  rdy_mode = 0;   // 0 always ready, 1 random, 2 stalled
  logic [31:0] lfsr = 32'h1bad_5eed;
  logic [DW-1:0] mem_m [logic [AW-1:0]];
  logic          p0_v = 1'b0, p1_v = 1'b0;
  logic [DW-1:0] p0_d = '0, p1_d = '0;
  logic [DW-1:0] spr_next = '0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 32'h5a5a_1234, ~a, a + 32'h0101_0101, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // memory, scratchpad and peripheral models plus scoreboard
  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    mem_rd_valid_i = p1_v;
    mem_rd_data_i  = p1_d;
    p1_v = p0_v; p1_d = p0_d; p0_v = 1'b0;
    spr_rdata_i = spr_next;
    mem_wr_gnt_i = (gnt_mode == 0) ? 1'b1 : lfsr[0];
    mem_rd_gnt_i = (gnt_mode == 0) ? 1'b1 : lfsr[3];
    case (rdy_mode)
      0: out_ready_i = 2'b11;
      1: out_ready_i = {lfsr[7], lfsr[5]};
      default: out_ready_i = 2'b00;
    endcase
    #1;
    spr_next = spr_req_o ? pat(spr_addr_o) : '0;
    if (mem_wr_req_o && mem_wr_gnt_i) begin
      chk(mem_wr_addr_o == (t_base | (AW'(wr_k) & t_mask)), "R3 write address",
          DW'(mem_wr_addr_o), DW'(t_base | (AW'(wr_k) & t_mask)));
      chk(mem_wr_data_o == pat(t_spr + AW'(wr_k)), "R3 write data",
          mem_wr_data_o, pat(t_spr + AW'(wr_k)));
      chk((wr_k + 1 - rd_k) <= t_size, "R5 ring never overfilled",
          DW'(wr_k + 1 - rd_k), DW'(t_size));
      mem_m[mem_wr_addr_o] = mem_wr_data_o;
      wr_k++;
    end
    if (mem_rd_req_o && mem_rd_gnt_i) begin
      chk(mem_rd_addr_o == (t_base | (AW'(rd_k) & t_mask)), "R4 read address",
          DW'(mem_rd_addr_o), DW'(t_base | (AW'(rd_k) & t_mask)));
      chk(rd_k < wr_k, "R6 read only written slot", DW'(rd_k), DW'(wr_k));
      p0_v = 1'b1;
      p0_d = mem_m.exists(mem_rd_addr_o) ? mem_m[mem_rd_addr_o] : '0;
      rd_k++;
    end
    if (out_valid_o[~t_sel] === 1'b1)
      chk(1'b0, "R4 unselected channel valid", DW'(out_valid_o), DW'(0));
    if (out_valid_o[t_sel] && out_ready_i[t_sel]) begin
      chk(out_data_o == pat(t_spr + AW'(out_k)), "R4 output order/data",
          out_data_o, pat(t_spr + AW'(out_k)));
      out_k++;
    end
  end

  task automatic kick(input logic [0:0] sel, input logic [3:0] lg, input int eff_lg,
                      input logic [AW-1:0] base, input logic [AW-1:0] spr,
                      input int cnt);
    @(negedge clk);
    t_sel = sel; t_base = base; t_spr = spr;
    t_size = 1 << eff_lg; t_mask = AW'(t_size - 1);
    wr_k = 0; rd_k = 0; out_k = 0;
    cfg_sel_i = sel; cfg_ring_log2_i = lg; cfg_ring_base_i = base;
    cfg_spr_base_i = spr; cfg_count_i = CW'(cnt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int max_cyc, input string req);
    int n = 0;
    while (!done_o && n < max_cyc) begin
      @(negedge clk);
      n++;
    end
    chk(done_o == 1'b1, req, DW'(done_o), DW'(1));
  endtask

  task automatic t_reset();
    chk({spr_req_o, mem_wr_req_o, mem_rd_req_o, out_valid_o, busy_o, done_o} == '0,
        "R1 reset outputs idle",
        DW'({spr_req_o, mem_wr_req_o, mem_rd_req_o, out_valid_o, busy_o, done_o}), DW'(0));
  endtask

  task automatic t_zero_count();
    kick(1'b0, 4'd3, 3, 32'h0000_1000, 32'h0000_0100, 0);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R8 zero count done at once",
        DW'({done_o, busy_o}), DW'(2'b10));
    repeat (5) @(negedge clk);
    chk(wr_k == 0 && rd_k == 0 && !spr_req_o, "R8 zero count no traffic",
        DW'(wr_k + rd_k), DW'(0));
  endtask

  task automatic t_basic();
    gnt_mode = 0; rdy_mode = 0;
    kick(1'b0, 4'd3, 3, 32'h0000_2000, 32'h0000_0040, 20);
    chk(busy_o == 1'b1 && done_o == 1'b0, "R2 start accepted, done cleared",
        DW'({busy_o, done_o}), DW'(2'b10));
    wait_done(500, "R7 basic job completes");
    chk(busy_o == 1'b0, "R7 busy falls with done", DW'(busy_o), DW'(0));
    chk(out_k == 20, "R4 basic word count", DW'(out_k), DW'(20));
    repeat (4) @(negedge clk);
    chk(done_o == 1'b1, "R7 done holds", DW'(done_o), DW'(1));
  endtask

  task automatic t_random_ch1();
    gnt_mode = 1; rdy_mode = 1;
    kick(1'b1, 4'd2, 2, 32'h0000_3000, 32'h0000_0200, 40);
    wait_done(2000, "R9 random handshakes complete");
    chk(out_k == 40 && wr_k == 40 && rd_k == 40, "R4 channel 1 all words",
        DW'(out_k), DW'(40));
  endtask

  task automatic t_stall();
    gnt_mode = 0; rdy_mode = 2;
    kick(1'b0, 4'd3, 3, 32'h0000_4000, 32'h0000_0300, 40);
    repeat (200) @(negedge clk);
    chk(wr_k == 8 + DRAIN_DEPTH, "R5 fill runs to full under stall",
        DW'(wr_k), DW'(8 + DRAIN_DEPTH));
    chk(rd_k == DRAIN_DEPTH && out_k == 0, "R5 drain held by stall",
        DW'(rd_k), DW'(DRAIN_DEPTH));
    rdy_mode = 0;
    wait_done(1000, "R5 job finishes after stall");
    chk(out_k == 40, "R5 all words after stall", DW'(out_k), DW'(40));
  endtask

  task automatic t_busy_start();
    gnt_mode = 1; rdy_mode = 1;
    kick(1'b0, 4'd4, 4, 32'h0000_5000, 32'h0000_0400, 30);
    repeat (10) @(negedge clk);
    cfg_sel_i = 1'b1; cfg_count_i = CW'(5);
    cfg_ring_base_i = 32'h0000_7000; cfg_spr_base_i = 32'h0000_0900;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(3000, "R2 first job finishes");
    chk(out_k == 30, "R2 start while busy ignored", DW'(out_k), DW'(30));
  endtask

  task automatic t_tiny();
    gnt_mode = 1; rdy_mode = 1;
    kick(1'b1, 4'd0, 0, 32'h0000_6000, 32'h0000_0500, 6);
    wait_done(1000, "R10 single slot ring completes");
    chk(out_k == 6 && wr_k == 6, "R10 single slot ring words", DW'(out_k), DW'(6));
  endtask

  task automatic t_clamp();
    gnt_mode = 0; rdy_mode = 0;
    kick(1'b0, 4'd15, 10, 32'h0001_0000, 32'h0000_0600, 12);
    wait_done(500, "R11 oversize log2 completes");
    chk(out_k == 12, "R11 oversize log2 words", DW'(out_k), DW'(12));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_basic();
    t_random_ch1();
    t_stall();
    t_busy_start();
    t_tiny();
    t_clamp();
    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule